// File: doc/BRIEF.md
# Indirect Dword Register Window

This block lets a controller with a large internal register file be reached through an 8-byte capability in configuration space. The capability holds a one-byte selector and a 32-bit data word. Software first writes the selector to pick a dword of the register file. It then reads the data word to see that dword's contents, or writes the data word to update it.

The block mirrors the selected dword into its own data register. Any write that touches the capability is forwarded to the register file as needed, and the data register is then reloaded from the selected dword. Configuration accesses are dword-addressed relative to the start of the capability and carry byte enables. The register file sits outside the block and is reached through a single-cycle port: writes land at the clock edge, and read data is returned combinationally for the address presented.

Top module: `idw_window`

## Requirements
- R1: Relative dword 0 reads as {flags, select, NEXT_PTR, CAP_ID}, from bit 31 down to bit 0. The flag byte (bits 31:24) reads zero after reset and is never changed by any write. The bytes at bits 15:0 are read-only.
- R2: Relative dword 1 reads the data register. Every other relative dword reads zero. Writes to those other dwords change nothing and trigger no register-file access.
- R3: The select byte (bits 23:16 of dword 0) is loaded only by a write to dword 0 with byte enable 2 set. Any other access leaves it unchanged.
- R4: A write to dword 1 with a nonzero byte enable merges the enabled bytes into the current data register. In the same cycle it presents the full 32-bit merged value on `rf_wdata_o` with `rf_we_o` high, and the data register holds the merged value afterwards.
- R5: The cycle after any write to dword 0 or 1 with a nonzero byte enable, `rf_re_o` is high. At that edge the data register loads `rf_rdata_i`, unless a data write in that same cycle takes priority.
- R6: When select ≥ RF_DWORDS, `rf_we_o` and `rf_re_o` stay low. The dropped write changes nothing, and a reload puts zero into the data register.
- R7: After reset, select and data are zero and a reload is pending, so dword 0 of the file is mirrored after the first cycle.
- R8: `rf_addr_o` always equals select × 4.
- R9: A write with all byte enables clear has no effect and triggers no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dw_i | input | CFG_DW_W | Dword index relative to the capability (read and write) |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_dw_i` |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_re_o | output | 1 | Register-file reload read strobe |
| rf_addr_o | output | 10 | Register-file byte address (select × 4) |
| rf_wdata_o | output | 32 | Register-file write data |
| rf_rdata_i | input | 32 | Register-file read data for `rf_addr_o` |

## Verification
The bench builds the block with RF_DWORDS = 6, so select values just inside, at and well past the end of the file are all reachable. This exercises the zero-on-reload and dropped-write path. NEXT_PTR is set to a nonzero value that differs from CAP_ID, so a swap of the header bytes or a write leaking into them shows up on the read port. A small 6-bit relative dword index lets writes to dwords beyond the capability be tried alongside a long pseudo-random mix of selector, data, partial-enable and zero-enable writes.

// File: rtl/idw_pkg.sv
package idw_pkg;
  localparam int unsigned SEL_W       = 8;
  localparam int unsigned ADDR_W      = SEL_W + 2;
  localparam int unsigned LANES       = 4;
  localparam int unsigned CAP_HDR_DW  = 0;
  localparam int unsigned CAP_DATA_DW = 1;
  localparam int unsigned SEL_LANE    = 2;
endpackage

// File: rtl/idw_cap_decode.sv
module idw_cap_decode
  import idw_pkg::*;
#(
  parameter int unsigned CFG_DW_W = 6
) (
  input  logic                cfg_we_i,
  input  logic [CFG_DW_W-1:0] cfg_dw_i,
  input  logic [LANES-1:0]    cfg_be_i,
  input  logic [31:0]         cfg_wdata_i,
  input  logic [31:0]         data_q_i,
  output logic                sel_wr_o,
  output logic [SEL_W-1:0]    sel_wdata_o,
  output logic                data_wr_o,
  output logic [31:0]         data_merged_o,
  output logic                cap_touch_o
);
  logic hit_hdr, hit_data, any_be;

  assign hit_hdr  = cfg_dw_i == CFG_DW_W'(CAP_HDR_DW);
  assign hit_data = cfg_dw_i == CFG_DW_W'(CAP_DATA_DW);
  assign any_be   = |cfg_be_i;

  assign sel_wr_o    = cfg_we_i && hit_hdr && cfg_be_i[SEL_LANE];
  assign sel_wdata_o = cfg_wdata_i[8*SEL_LANE +: 8];
  assign data_wr_o   = cfg_we_i && hit_data && any_be;
  assign cap_touch_o = cfg_we_i && (hit_hdr || hit_data) && any_be;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_merged_o[8*g +: 8] = cfg_be_i[g] ? cfg_wdata_i[8*g +: 8]
                                                 : data_q_i[8*g +: 8];
  end
endmodule

// File: rtl/idw_window_regs.sv
module idw_window_regs
  import idw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  input  logic             data_wr_i,
  input  logic [31:0]      data_merged_i,
  input  logic             cap_touch_i,
  input  logic [31:0]      reload_word_i,
  output logic [SEL_W-1:0] sel_q_o,
  output logic [31:0]      data_q_o,
  output logic             pend_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q_o  <= '0;
      data_q_o <= '0;
      pend_q_o <= 1'b1;
    end else begin
      if (sel_wr_i) sel_q_o <= sel_wdata_i;
      // forwarded write wins over a pending reload
      if (data_wr_i)     data_q_o <= data_merged_i;
      else if (pend_q_o) data_q_o <= reload_word_i;
      pend_q_o <= cap_touch_i;
    end
  end

  assert_sel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr_i |=> $stable(sel_q_o));

  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_wr_i && !pend_q_o) |=> $stable(data_q_o));
endmodule

// File: rtl/idw_rf_port.sv
module idw_rf_port
  import idw_pkg::*;
#(
  parameter int unsigned RF_DWORDS = 64
) (
  input  logic              sel_q_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              data_wr_i,
  input  logic [31:0]       data_merged_i,
  input  logic [31:0]       rf_rdata_i,
  output logic              rf_we_o,
  output logic              rf_re_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [31:0]       rf_wdata_o,
  output logic [31:0]       reload_word_o,
  output logic              in_range_o
);
  assign in_range_o    = 32'(sel_i) < 32'(RF_DWORDS);
  assign rf_addr_o     = {sel_i, 2'b00};
  assign rf_we_o       = data_wr_i && in_range_o;
  assign rf_re_o       = sel_q_i && in_range_o;
  assign rf_wdata_o    = data_merged_i;
  assign reload_word_o = in_range_o ? rf_rdata_i : '0;
endmodule

// File: rtl/idw_window.sv
module idw_window
  import idw_pkg::*;
#(
  parameter int unsigned CFG_DW_W  = 6,
  parameter int unsigned RF_DWORDS = 64,
  parameter logic [7:0]  CAP_ID    = 8'h0C,
  parameter logic [7:0]  NEXT_PTR  = 8'h00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_DW_W-1:0] cfg_dw_i,
  input  logic [3:0]          cfg_be_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  output logic                rf_we_o,
  output logic                rf_re_o,
  output logic [9:0]          rf_addr_o,
  output logic [31:0]         rf_wdata_o,
  input  logic [31:0]         rf_rdata_i
);
  logic             sel_wr, data_wr, cap_touch, pend_q, in_range;
  logic [SEL_W-1:0] sel_wdata, sel_q;
  logic [31:0]      data_merged, data_q, reload_word;

  idw_cap_decode #(.CFG_DW_W(CFG_DW_W)) u_dec (
    .cfg_we_i     (cfg_we_i),
    .cfg_dw_i     (cfg_dw_i),
    .cfg_be_i     (cfg_be_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .data_q_i     (data_q),
    .sel_wr_o     (sel_wr),
    .sel_wdata_o  (sel_wdata),
    .data_wr_o    (data_wr),
    .data_merged_o(data_merged),
    .cap_touch_o  (cap_touch)
  );

  idw_window_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_wr_i     (sel_wr),
    .sel_wdata_i  (sel_wdata),
    .data_wr_i    (data_wr),
    .data_merged_i(data_merged),
    .cap_touch_i  (cap_touch),
    .reload_word_i(reload_word),
    .sel_q_o      (sel_q),
    .data_q_o     (data_q),
    .pend_q_o     (pend_q)
  );

  idw_rf_port #(.RF_DWORDS(RF_DWORDS)) u_rf (
    .sel_q_i      (pend_q),
    .sel_i        (sel_q),
    .data_wr_i    (data_wr),
    .data_merged_i(data_merged),
    .rf_rdata_i   (rf_rdata_i),
    .rf_we_o      (rf_we_o),
    .rf_re_o      (rf_re_o),
    .rf_addr_o    (rf_addr_o),
    .rf_wdata_o   (rf_wdata_o),
    .reload_word_o(reload_word),
    .in_range_o   (in_range)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_dw_i == CFG_DW_W'(CAP_HDR_DW))
      cfg_rdata_o = {8'h00, sel_q, NEXT_PTR, CAP_ID};
    else if (cfg_dw_i == CFG_DW_W'(CAP_DATA_DW))
      cfg_rdata_o = data_q;
  end

  assert_reload_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_touch |=> pend_q);

  assert_fwd_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> (data_q == $past(rf_wdata_o)));

  assert_oob_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !in_range && !data_wr) |=> (data_q == '0));
endmodule

// File: tb/sim_idw_window.sv
module sim_idw_window;
  localparam int N    = 6;
  localparam int DWW  = 6;
  localparam logic [7:0] CID = 8'h0C;
  localparam logic [7:0] NXT = 8'h48;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cfg_we = 1'b0;
  logic [DWW-1:0] cfg_dw = '0;
  logic [3:0]     cfg_be = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [31:0]    cfg_rdata;
  logic           rf_we, rf_re;
  logic [9:0]     rf_addr;
  logic [31:0]    rf_wdata, rf_rdata;

  int n_chk = 0, n_bad = 0;

  logic [31:0] mem [N];
  logic [31:0] m_file [N];
  logic [7:0]  m_sel = 8'h00;
  logic [31:0] m_data = 32'h0;
  logic        m_pend = 1'b1;

  always #2 clk = ~clk;

  idw_window #(.CFG_DW_W(DWW), .RF_DWORDS(N), .CAP_ID(CID), .NEXT_PTR(NXT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_dw_i(cfg_dw),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .rf_we_o(rf_we), .rf_re_o(rf_re), .rf_addr_o(rf_addr),
    .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
  );

  // backing register file stub; garbage past the end
  assign rf_rdata = (int'(rf_addr[9:2]) < N) ? mem[rf_addr[9:2]] : 32'hBAD0_BAD0;

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i]    = 32'h1000_0000 + i * 32'h0101_0101;
      m_file[i] = 32'h1000_0000 + i * 32'h0101_0101;
    end
  end

  always @(posedge clk) if (rf_we && int'(rf_addr[9:2]) < N) mem[rf_addr[9:2]] <= rf_wdata;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] w, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = w[8*b +: 8];
    return r;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_sel = 8'h00; m_data = 32'h0; m_pend = 1'b1;
    end else begin
      logic in, dwr, touch;
      logic [31:0] mg;
      in    = int'(m_sel) < N;
      dwr   = cfg_we && cfg_dw == 1 && cfg_be != 0;
      touch = cfg_we && (cfg_dw == 0 || cfg_dw == 1) && cfg_be != 0;
      mg    = merge(m_data, cfg_wdata, cfg_be);
      if (dwr) begin
        if (in) m_file[m_sel] = mg;
        m_data = mg;
      end else if (m_pend) begin
        m_data = in ? m_file[m_sel] : 32'h0;
      end
      if (cfg_we && cfg_dw == 0 && cfg_be[2]) m_sel = cfg_wdata[23:16];
      m_pend = touch;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    logic in, dwr;
    string tg;
    in  = int'(m_sel) < N;
    dwr = cfg_we && cfg_dw == 1 && cfg_be != 0;
    tg  = (cfg_we && cfg_be == 0) ? "R9" : (!in ? "R6" : "R4");
    if (cfg_dw == 0)
      check("R1", "hdr rdata", cfg_rdata, {8'h00, m_sel, NXT, CID});
    else if (cfg_dw == 1)
      check(rst_ni ? "R5" : "R7", "data rdata", cfg_rdata, m_data);
    else
      check("R2", "other rdata", cfg_rdata, 32'h0);
    check(tg, "rf_we", {31'h0, rf_we}, {31'h0, dwr && in});
    check(in ? "R5" : "R6", "rf_re", {31'h0, rf_re}, {31'h0, m_pend && in});
    check("R8", "rf_addr", {22'h0, rf_addr}, {22'h0, m_sel, 2'b00});
    if (dwr) check("R4", "rf_wdata", rf_wdata, merge(m_data, cfg_wdata, cfg_be));
  end

  task automatic wr(int dw, logic [3:0] be, logic [31:0] d);
    cfg_we = 1'b1; cfg_dw = DWW'(dw); cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic idle(int n, int dw);
    cfg_dw = DWW'(dw);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sel_to(int s);
    wr(0, 4'b0100, {8'h00, 8'(s), 16'h0000});
    idle(1, 1);
  endtask

  task automatic finish_run();
    for (int i = 0; i < N; i++) check("R4", "file contents", mem[i], m_file[i]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    idle(1, 0);
    rst_ni = 1'b1;                           // R7: first cycle reloads dword 0
    idle(2, 1);
    idle(1, 0);
    sel_to(3);                               // R3, R5
    idle(1, 0);
    wr(1, 4'hF, 32'hCAFE_F00D); idle(2, 1);  // R4 full
    wr(1, 4'b0101, 32'h1122_3344); idle(2, 1);  // R4 partial merge
    wr(0, 4'b0011, 32'hFFFF_FFFF); idle(2, 0);  // R1 RO bytes, still reloads
    wr(0, 4'b1000, 32'hFF00_0000); idle(1, 0);  // R1 flag byte
    wr(1, 4'b0000, 32'hDEAD_DEAD); idle(2, 1);  // R9
    wr(2, 4'hF, 32'h5555_5555); idle(1, 2);     // R2
    wr(5, 4'hF, 32'h6666_6666); idle(1, 1);     // R2
    sel_to(N - 1); wr(1, 4'hF, 32'h0BAD_CAFE); idle(2, 1);
    sel_to(N);     wr(1, 4'hF, 32'h7777_7777); idle(2, 1);  // R6
    sel_to(255);   wr(1, 4'b0010, 32'h0000_9900); idle(2, 1);
    // back-to-back: select then data, data during reload
    wr(0, 4'b0100, 32'h0001_0000);
    wr(1, 4'hF, 32'hA5A5_0001);
    wr(1, 4'b1000, 32'h3C00_0000);
    wr(0, 4'b0100, 32'h0004_0000);
    idle(2, 1);
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd0, 3'd1: wr(0, 4'b0100, {8'h00, 5'h0, lf[5:3], 16'h0});
        3'd2, 3'd3, 3'd4: wr(1, lf[9:6], {lf, lf ^ 16'h5A5A});
        3'd5: wr(int'(lf[8:6]), lf[12:9], {lf ^ 16'h0F0F, lf});
        default: idle(1, int'(lf[4:3]));
      endcase
    end
    idle(3, 1);
    finish_run();
  end
endmodule